// File: doc/BRIEF.md
# Cache Identification Register Bank

This block answers system-control coprocessor accesses aimed at the cache identification registers. Each access is one 32-bit encoded word plus a read/write flag, presented for one cycle with a valid strobe. The block pulls the primary register number, the secondary register number and both opcode fields out of that word. It then decides whether the encoding is supported, and either returns read data, captures a new cache selection, or raises an undefined-access pulse so the pipeline can trap.

The bank holds a 4-bit selection register, a fixed table of sixteen cache-size descriptors, a cache-level word and a cache-type word. A size-descriptor read is indirect: software first writes the selection register, then reads the descriptor that the selection points at. A feature input switches the newer (v7) behaviour on. With it off, the selection cannot be written and the level/size reads return zero.

Top module: `cache_id_regbank`

## Requirements
- R1: After reset, the read data is 0, the undefined flag is low and the selection register holds 0.
- R2: The access word is decoded as secondary register number in bits [3:0], opcode-2 in bits [7:5], primary register number in bits [19:16] and opcode-1 in bits [23:21]. All other bits have no effect.
- R3: With v7 enabled, a write with primary 0, opcode-1 2, secondary 0 and opcode-2 0 stores write-data bits [3:0] into the selection register. The upper write-data bits are ignored, and the write itself returns zero data and no undefined pulse.
- R4: Every other write flags undefined and leaves the selection unchanged. This covers the selection encoding when v7 is disabled and any write with a nonzero primary register.
- R5: A read with primary 0 and opcode-1 1 flags undefined when the secondary register is nonzero, whatever the v7 setting.
- R6: A read with primary 0, opcode-1 1 and secondary 0 returns zero when v7 is disabled, for every opcode-2.
- R7: With v7 enabled, a read with primary 0, opcode-1 1, secondary 0 and opcode-2 0 returns the descriptor indexed by the selection. The descriptors are: index 0 = 0xE007E01A, index 1 = 0x2007E01A, index 2 = 0xF0000000, indices 3 to 15 = 0.
- R8: With v7 enabled, a read at primary 0, opcode-1 1, secondary 0 returns the cache-level word 0x0A000003 for opcode-2 1 and zero for opcode-2 7. Any other opcode-2 flags undefined.
- R9: A read with primary 0 and opcode-1 2 returns the selection register when opcode-2 and the secondary register are both 0, and flags undefined otherwise.
- R10: A read with primary 0, opcode-1 0, secondary 0 and opcode-2 1 returns the cache-type word 0x82048004. Every other read with opcode-1 0, opcode-1 3 to 7, or a nonzero primary register flags undefined.
- R11: Read data and the undefined flag are registered and appear exactly one cycle after the strobe, for that single cycle. In all other cycles both are zero, and an undefined access returns zero data.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| v7_en | input | 1 | Enables the v7 cache identification behaviour |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 32 | Encoded access word with register numbers and opcodes |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| undef_o | output | 1 | One-cycle undefined-access pulse, the cycle after the strobe |

## Verification
Directed accesses walk every opcode-1/opcode-2/secondary combination of primary register 0, with v7 on and off. These show whether each encoding is routed to the right source or trapped. Selection writes followed by descriptor reads over all sixteen indices tell an indirect lookup apart from a fixed one. Write data with noisy upper bits shows whether only the low nibble is kept. Random access words are mostly aimed at primary register 0 and carry random noise in the undecoded bits. They expose wrong field positions and interactions between a stale selection and later reads.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [2:0] {
    K_UNDEF  = 3'd0,
    K_SEL_WR = 3'd1,
    K_ZERO   = 3'd2,
    K_DESC   = 3'd3,
    K_LEVEL  = 3'd4,
    K_SEL_RD = 3'd5,
    K_TYPE   = 3'd6
  } cid_kind_e;

  typedef struct packed {
    logic [3:0] crn;
    logic [2:0] op1;
    logic [3:0] crm;
    logic [2:0] op2;
  } cid_fields_t;

  localparam logic [31:0] CID_LEVEL_WORD = (32'd1 << 27) | (32'd2 << 24) | 32'd3;
  localparam logic [31:0] CID_TYPE_WORD  = 32'h8204_8004;

  // Field positions of the access word.
  function automatic cid_fields_t cid_split(input logic [31:0] w);
    cid_fields_t f;
    f.crm = w[3:0];
    f.op2 = w[7:5];
    f.crn = w[19:16];
    f.op1 = w[23:21];
    return f;
  endfunction

  // Reset content of the size-descriptor table.
  function automatic logic [31:0] cid_desc_init(input int unsigned idx);
    case (idx)
      0:       return 32'hE007_E01A;
      1:       return 32'h2007_E01A;
      2:       return 32'hF000_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cid_decode.sv
module cid_decode
  import cid_pkg::*;
(
  input  logic        acc_write,
  input  logic [31:0] acc_word,
  input  logic        v7_en,
  output cid_kind_e   kind
);

  cid_fields_t f;
  logic        crm_zero;

  always_comb begin
    f        = cid_split(acc_word);
    crm_zero = (f.crm == 4'd0);
    kind     = K_UNDEF;
    if (f.crn == 4'd0) begin
      if (acc_write) begin
        if (v7_en && f.op1 == 3'd2 && crm_zero && f.op2 == 3'd0)
          kind = K_SEL_WR;
      end else begin
        case (f.op1)
          3'd0: if (crm_zero && f.op2 == 3'd1) kind = K_TYPE;
          3'd1: begin
            if (crm_zero) begin
              if (!v7_en) kind = K_ZERO;
              else begin
                case (f.op2)
                  3'd0:    kind = K_DESC;
                  3'd1:    kind = K_LEVEL;
                  3'd7:    kind = K_ZERO;
                  default: kind = K_UNDEF;
                endcase
              end
            end
          end
          3'd2: if (crm_zero && f.op2 == 3'd0) kind = K_SEL_RD;
          default: kind = K_UNDEF;
        endcase
      end
    end
  end

endmodule

// File: rtl/cid_desc_table.sv
module cid_desc_table
  import cid_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] sel_wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] desc_out
);

  localparam int unsigned NUM_DESC = 1 << SEL_W;

  function automatic logic [SEL_W-1:0] low_sel(input logic [DATA_W-1:0] d);
    return d[SEL_W-1:0];
  endfunction

  logic [DATA_W-1:0] tbl [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    assign tbl[i] = DATA_W'(cid_desc_init(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= low_sel(sel_wdata);
  end

  assign desc_out = tbl[sel_q];

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));

  assert_sel_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(sel_wdata[SEL_W-1:0]));

endmodule

// File: rtl/cache_id_regbank.sv
module cache_id_regbank
  import cid_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v7_en,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [31:0]       acc_word,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              undef_o
);

  cid_kind_e         kind;
  logic              sel_we;
  logic              undef_evt;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] desc_out;
  logic [DATA_W-1:0] rd_next;

  cid_decode u_dec (
    .acc_write (acc_write),
    .acc_word  (acc_word),
    .v7_en     (v7_en),
    .kind      (kind)
  );

  assign sel_we    = acc_valid && (kind == K_SEL_WR);
  assign undef_evt = acc_valid && (kind == K_UNDEF);

  cid_desc_table #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we),
    .sel_wdata (acc_wdata),
    .sel_q     (sel_q),
    .desc_out  (desc_out)
  );

  always_comb begin
    rd_next = '0;
    if (acc_valid) begin
      case (kind)
        K_DESC:   rd_next = desc_out;
        K_LEVEL:  rd_next = DATA_W'(CID_LEVEL_WORD);
        K_TYPE:   rd_next = DATA_W'(CID_TYPE_WORD);
        K_SEL_RD: rd_next = DATA_W'(sel_q);
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      undef_o <= 1'b0;
    end else begin
      rd_data <= rd_next;
      undef_o <= undef_evt;
    end
  end

  assert_undef_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> rd_data == '0);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (rd_data == '0) && !undef_o);

  assert_sel_we_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |-> acc_write && v7_en);

  assert_write_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> rd_data == '0);

endmodule

// File: tb/sim_cache_id_regbank.sv
`timescale 1ns/1ps
module sim_cache_id_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v7_en = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_word = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        undef_o;

  int unsigned vec_cnt = 0;
  int unsigned err_cnt = 0;
  logic [3:0]  sel_m = 4'd0;

  always #2 clk = ~clk;

  cache_id_regbank u0 (
    .clk (clk), .rst_n (rst_n), .v7_en (v7_en),
    .acc_valid (acc_valid), .acc_write (acc_write),
    .acc_word (acc_word), .acc_wdata (acc_wdata),
    .rd_data (rd_data), .undef_o (undef_o)
  );

  function automatic logic [31:0] ref_desc(input logic [3:0] s);
    if (s == 4'd0) return 32'hE007E01A;
    if (s == 4'd1) return 32'h2007E01A;
    if (s == 4'd2) return 32'hF0000000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] crn, input logic [2:0] op1,
                                     input logic [3:0] crm, input logic [2:0] op2,
                                     input logic [31:0] noise);
    return (noise & ~32'h00EF00EF) | {8'h0, op1, 1'b0, crn, 8'h0, op2, 1'b0, crm};
  endfunction

  function automatic void ref_model(input logic [31:0] w, input bit wr, input bit v7,
                                    input logic [3:0] s, output bit und,
                                    output logic [31:0] dat, output string tag);
    logic [3:0] crn = w[19:16];
    logic [2:0] o1 = w[23:21];
    logic [3:0] crm = w[3:0];
    logic [2:0] o2 = w[7:5];
    und = 1'b1; dat = 32'h0; tag = "R10";
    if (crn != 0) begin tag = wr ? "R4" : "R10"; return; end
    if (wr) begin
      tag = "R4";
      if (v7 && o1 == 2 && crm == 0 && o2 == 0) begin und = 1'b0; tag = "R3"; end
      return;
    end
    if (o1 == 1) begin
      if (crm != 0) begin tag = "R5"; return; end
      if (!v7) begin und = 1'b0; tag = "R6"; return; end
      tag = "R8";
      if (o2 == 0) begin und = 1'b0; dat = ref_desc(s); tag = "R7"; end
      else if (o2 == 1) begin und = 1'b0; dat = 32'h0A000003; end
      else if (o2 == 7) und = 1'b0;
    end else if (o1 == 2) begin
      tag = "R9";
      if (crm == 0 && o2 == 0) begin und = 1'b0; dat = {28'h0, s}; end
    end else if (o1 == 0 && crm == 0 && o2 == 1) begin
      und = 1'b0; dat = 32'h82048004;
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge after checking.
  task automatic apply(input logic [31:0] w, input bit wr, input logic [31:0] d, input bit v7);
    bit e_und; logic [31:0] e_dat; string tag;
    ref_model(w, wr, v7, sel_m, e_und, e_dat, tag);
    v7_en = v7; acc_word = w; acc_write = wr; acc_wdata = d; acc_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " undef"}, {31'h0, undef_o}, {31'h0, e_und});
    chk({tag, " data"}, rd_data, e_dat);
    if (wr && !e_und) sel_m = d[3:0];
  endtask

  task automatic idle_chk();
    @(posedge clk); @(negedge clk);
    chk("R11 idle undef", {31'h0, undef_o}, 32'h0);
    chk("R11 idle data", rd_data, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset data", rd_data, 32'h0);
    chk("R1 reset undef", {31'h0, undef_o}, 32'h0);
    apply(mk(0, 2, 0, 0, 0), 0, 0, 1);                       // R1 selection reads 0
    apply(mk(0, 1, 0, 0, 0), 0, 0, 1);                       // R7 descriptor 0
    apply(mk(0, 1, 0, 1, 0), 0, 0, 1);                       // R8 level
    apply(mk(0, 1, 0, 7, 0), 0, 0, 1);                       // R8 zero
    apply(mk(0, 1, 0, 3, 0), 0, 0, 1);                       // R8 undefined
    apply(mk(0, 0, 0, 1, 32'hFF10_FF10), 0, 0, 1);           // R10 + R2 noise bits
    apply(mk(0, 0, 0, 0, 0), 0, 0, 1);                       // R10 undefined
    apply(mk(5, 1, 0, 0, 0), 0, 0, 1);                       // R10 nonzero primary
    apply(mk(0, 1, 4'h3, 0, 0), 0, 0, 1);                    // R5
    apply(mk(0, 1, 4'h3, 0, 0), 0, 0, 0);                    // R5 with v7 off
    for (int i = 0; i < 8; i++) apply(mk(0, 1, 0, 3'(i), 0), 0, 0, 0); // R6
    apply(mk(0, 2, 0, 0, 0), 1, 32'hABCD_EF05, 0);           // R4 v7 off write
    apply(mk(0, 2, 0, 0, 0), 0, 0, 1);                       // R4 selection unchanged
    apply(mk(0, 2, 0, 1, 0), 1, 32'h7, 1);                   // R4 wrong op2
    apply(mk(3, 2, 0, 0, 0), 1, 32'h7, 1);                   // R4 nonzero primary
    apply(mk(0, 2, 0, 0, 0), 0, 0, 1);                       // R9 still 0
    apply(mk(0, 2, 1, 0, 0), 0, 0, 1);                       // R9 undefined
    for (int i = 0; i < 16; i++) begin                       // R3 / R7 all indices
      apply(mk(0, 2, 0, 0, 32'h0F00_0F00), 1, 32'hFFFF_FFF0 | 32'(i), 1);
      apply(mk(0, 2, 0, 0, 0), 0, 0, 1);
      apply(mk(0, 1, 0, 0, 0), 0, 0, 1);
    end
    idle_chk();                                              // R11
    for (int n = 0; n < 600; n++) begin                      // R2 random mix
      logic [3:0] crn; logic [2:0] o1; logic [3:0] crm;
      crn = ($urandom % 8 == 0) ? 4'($urandom) : 4'd0;
      o1  = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
      crm = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
      apply(mk(crn, o1, crm, 3'($urandom), $urandom), bit'($urandom % 3 == 0),
            $urandom, bit'($urandom % 5 != 0));
      if (n % 50 == 0) idle_chk();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule